// File: doc/BRIEF.md
# Commit Head Sequencer

This block sits between a reorder buffer and the rest of an out-of-order core and decides, every cycle, which of the presented reorder-buffer heads leave the machine. An external thread selector lines up a short list of candidate heads, one per examination slot. Each candidate carries a thread number, a sequence number, the address of the instruction that follows it, and a set of flags. The block walks the slots in order and stops at the first head that cannot leave. It retires squashed heads for free and commits executed ones up to a fixed width. For a head that has not executed, it either asks the back end for a non-speculative or uncached replay or makes the cycle wait. For a faulting head it either raises a trap or waits.

The per-slot decisions are combinational, so the reorder buffer can pop its heads in the same cycle. The block also keeps a small amount of state: for each thread, the sequence number of the newest committed instruction and its restart addresses; a running total of counted instructions; a count of cycles in which the width limit was reached; and a sticky error for heads of a kind it cannot handle.

Top module: `hsq_commit_seq`

## Requirements
- R1: Examination runs through the slots in order. It stops at the first slot that has no valid selection, whose head is not ready, or that comes after COMMIT_W commits have already been made in the cycle. No more than COMMIT_W commits happen in a cycle, and `used_cnt_o` reports how many there were.
- R2: A head with flag bit 0 (squashed) set is retired. It does not raise `used_cnt_o` and does not use up width, and examination goes on to the next slot.
- R3: A head that has not executed (flag bit 1 clear) is held with no request when all of the following hold: it has non-speculative (bit 2), store-conditional (bit 3), memory-barrier (bit 4) or write-barrier (bit 5) set; it has bit 4, bit 5 or quiesce (bit 6) set; and `stores_pend_i` is high. Examination stops there.
- R4: Otherwise, an unexecuted head in the group made of bits 2 to 5 raises `nonspec_req_o` with its thread and sequence number only if no commit came before it in the cycle. In either case examination stops there.
- R5: An unexecuted head outside that group with load (bit 7) set raises `uncached_req_o` with its thread and sequence number, and examination stops there.
- R6: An executed head with fault (bit 8) set raises `trap_req_o` with its thread only if `stores_pend_i` is low and it is the first commit candidate of the cycle. Otherwise it waits. Examination stops in both cases, and the faulting head is not retired.
- R7: Every other executed head commits. The committing thread's done sequence number becomes the head's sequence number, its PC becomes the head's next address, and its next PC becomes that address plus 4. When several heads of one thread commit in the same cycle, the one in the highest slot wins.
- R8: `insn_cnt_o` counts the commits of a cycle, leaving out heads with nop (bit 9) or instruction prefetch (bit 10) set. `insn_total_o` adds it up across cycles.
- R9: `bw_events_o` goes up by one after every cycle in which `used_cnt_o` equals COMMIT_W.
- R10: An unexecuted head that is in none of the cases above stops examination and sets `err_o`, which stays high until reset.
- R11: While reset is asserted and after it is released, all per-thread state, the totals and `err_o` read zero until the first commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld_i | input | N_SLOT | The selector picked a thread for this slot |
| slot_rdy_i | input | N_SLOT | The slot's head is ready for examination |
| slot_tid_i | input | N_SLOT x TID_W | Thread of each head |
| slot_seq_i | input | N_SLOT x SEQ_W | Sequence number of each head |
| slot_npc_i | input | N_SLOT x PC_W | Address of the instruction after each head |
| slot_flags_i | input | N_SLOT x 11 | Head flags; bit positions as given in the requirements |
| stores_pend_i | input | 1 | Stores are still waiting for writeback |
| retire_o | output | N_SLOT | Pop this slot's head this cycle |
| used_cnt_o | output | CW | Commits made this cycle |
| insn_cnt_o | output | CW | Commits this cycle that are not nops or prefetches |
| nonspec_req_o | output | 1 | Non-speculative execution request |
| uncached_req_o | output | 1 | Uncached load replay request |
| trap_req_o | output | 1 | Trap request |
| req_tid_o | output | TID_W | Thread of the active request |
| req_seq_o | output | SEQ_W | Sequence number of the active request |
| done_seq_o | output | THREADS x SEQ_W | Newest committed sequence number of each thread |
| pc_o | output | THREADS x PC_W | PC of each thread |
| npc_o | output | THREADS x PC_W | Next PC of each thread |
| insn_total_o | output | CNT_W | Running total of counted instructions |
| bw_events_o | output | CNT_W | Cycles that used the full width |
| err_o | output | 1 | Sticky error: unhandled unexecuted head |

## Verification
The bench goes after the places where slot order matters. Squashed heads ahead of a full set of commits must all be popped: a design that charged them to the width would leave executed heads behind. A non-speculative head or a fault sitting in slot one behind a commit must neither issue its request nor trap, or it would act before the older instruction had left. A barrier with stores pending and a faulting head with stores pending must hold the whole cycle; a design that ignored the drain would issue a request or trap early. Two same-thread commits in one cycle must leave the younger sequence number and addresses, and nops must retire without counting, or the per-thread state and totals drift.

// File: rtl/hsq_pkg.sv
package hsq_pkg;
  // flag bit positions inside one head descriptor
  localparam int FL_SQUASH  = 0;
  localparam int FL_EXEC    = 1;
  localparam int FL_NONSPEC = 2;
  localparam int FL_STCOND  = 3;
  localparam int FL_MEMBAR  = 4;
  localparam int FL_WRBAR   = 5;
  localparam int FL_QUIESCE = 6;
  localparam int FL_LOAD    = 7;
  localparam int FL_FAULT   = 8;
  localparam int FL_NOP     = 9;
  localparam int FL_IPREF   = 10;
  localparam int FLAG_W     = 11;

  localparam int INSN_BYTES = 4;

  typedef enum logic [2:0] {
    ACT_NONE,      // slot not examined or stopped without action
    ACT_RETIRE_SQ, // squashed head popped for free
    ACT_COMMIT,    // executed head committed
    ACT_NONSPEC,   // non-speculative request sent
    ACT_UNCACHED,  // uncached load request sent
    ACT_TRAP,      // trap raised
    ACT_ERROR,     // unhandled unexecuted head
    ACT_WAIT       // head must wait, cycle ends
  } slot_act_e;
endpackage

// File: rtl/hsq_slot_eval.sv
module hsq_slot_eval
  import hsq_pkg::*;
#(
  parameter int COMMIT_W = 4,
  parameter int CW       = 3
) (
  input  logic              go_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic              vld_i,
  input  logic              rdy_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              stores_pend_i,
  output logic              go_o,
  output logic [CW-1:0]     cnt_o,
  output slot_act_e         act_o
);
  logic avail;
  logic first;
  logic ns_grp;
  logic drain_need;

  assign avail      = go_i && (cnt_i < CW'(COMMIT_W)) && vld_i && rdy_i;
  assign first      = (cnt_i == '0);
  assign ns_grp     = flags_i[FL_NONSPEC] | flags_i[FL_STCOND] |
                      flags_i[FL_MEMBAR]  | flags_i[FL_WRBAR];
  assign drain_need = flags_i[FL_MEMBAR] | flags_i[FL_WRBAR] | flags_i[FL_QUIESCE];

  always_comb begin
    act_o = ACT_NONE;
    if (avail) begin
      if (flags_i[FL_SQUASH]) begin
        act_o = ACT_RETIRE_SQ;
      end else if (!flags_i[FL_EXEC]) begin
        if (ns_grp) begin
          if (drain_need && stores_pend_i) act_o = ACT_WAIT;
          else if (first)                  act_o = ACT_NONSPEC;
          else                             act_o = ACT_WAIT;
        end else if (flags_i[FL_LOAD]) begin
          act_o = ACT_UNCACHED;
        end else begin
          act_o = ACT_ERROR;
        end
      end else if (flags_i[FL_FAULT]) begin
        act_o = (!stores_pend_i && first) ? ACT_TRAP : ACT_WAIT;
      end else begin
        act_o = ACT_COMMIT;
      end
    end
  end

  assign go_o  = (act_o == ACT_RETIRE_SQ) || (act_o == ACT_COMMIT);
  assign cnt_o = cnt_i + ((act_o == ACT_COMMIT) ? CW'(1) : CW'(0));
endmodule

// File: rtl/hsq_thread_state.sv
module hsq_thread_state
  import hsq_pkg::*;
#(
  parameter int TID    = 0,
  parameter int N_SLOT = 6,
  parameter int TID_W  = 1,
  parameter int SEQ_W  = 16,
  parameter int PC_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SLOT-1:0]             commit_i,
  input  logic [N_SLOT-1:0][TID_W-1:0]  tid_i,
  input  logic [N_SLOT-1:0][SEQ_W-1:0]  seq_i,
  input  logic [N_SLOT-1:0][PC_W-1:0]   npc_i,
  output logic [SEQ_W-1:0]              done_seq_o,
  output logic [PC_W-1:0]               pc_o,
  output logic [PC_W-1:0]               npc_o
);
  logic             hit;
  logic [SEQ_W-1:0] seq_d, seq_q;
  logic [PC_W-1:0]  pc_d, pc_q;
  logic [PC_W-1:0]  npc_d, npc_q;

  // later slots override earlier ones for the same thread
  always_comb begin
    hit   = 1'b0;
    seq_d = seq_q;
    pc_d  = pc_q;
    npc_d = npc_q;
    for (int k = 0; k < N_SLOT; k++) begin
      if (commit_i[k] && (tid_i[k] == TID_W'(TID))) begin
        hit   = 1'b1;
        seq_d = seq_i[k];
        pc_d  = npc_i[k];
        npc_d = npc_i[k] + PC_W'(INSN_BYTES);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
      pc_q  <= '0;
      npc_q <= '0;
    end else if (hit) begin
      seq_q <= seq_d;
      pc_q  <= pc_d;
      npc_q <= npc_d;
    end
  end

  assign done_seq_o = seq_q;
  assign pc_o       = pc_q;
  assign npc_o      = npc_q;

  AST_THREAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(seq_q) && $stable(pc_q)) // R7
    else $error("thread state moved without a commit");
  AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (npc_q == pc_q + PC_W'(INSN_BYTES))) // R7
    else $error("next pc not one instruction past pc");
endmodule

// File: rtl/hsq_stats.sv
module hsq_stats #(
  parameter int COMMIT_W = 4,
  parameter int CW       = 3,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    used_cnt_i,
  input  logic [CW-1:0]    insn_cnt_i,
  input  logic             err_evt_i,
  output logic [CNT_W-1:0] insn_total_o,
  output logic [CNT_W-1:0] bw_events_o,
  output logic             err_o
);
  logic [CNT_W-1:0] total_d, total_q;
  logic [CNT_W-1:0] bw_d, bw_q;
  logic             err_d, err_q;
  logic             full;
  logic             total_en;

  assign full     = (used_cnt_i == CW'(COMMIT_W));
  assign total_en = (insn_cnt_i != '0);

  always_comb begin
    total_d = total_q + CNT_W'(insn_cnt_i);
    bw_d    = bw_q + CNT_W'(1);
    err_d   = err_q | err_evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      bw_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      if (total_en) total_q <= total_d;
      if (full)     bw_q    <= bw_d;
      err_q <= err_d;
    end
  end

  assign insn_total_o = total_q;
  assign bw_events_o  = bw_q;
  assign err_o        = err_q;

  AST_BW_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (bw_q == $past(bw_q) + CNT_W'(1))) // R9
    else $error("full-width cycle not counted");
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q) // R10
    else $error("error flag dropped");
  AST_INSN_LE_USED: assert property (@(posedge clk) disable iff (!rst_n)
    insn_cnt_i <= used_cnt_i) // R8
    else $error("counted more instructions than commits");
endmodule

// File: rtl/hsq_commit_seq.sv
module hsq_commit_seq
  import hsq_pkg::*;
#(
  parameter int N_SLOT   = 6,
  parameter int COMMIT_W = 4,
  parameter int THREADS  = 2,
  parameter int SEQ_W    = 16,
  parameter int PC_W     = 32,
  parameter int CNT_W    = 32,
  localparam int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int CW      = $clog2(COMMIT_W + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_SLOT-1:0]              slot_vld_i,
  input  logic [N_SLOT-1:0]              slot_rdy_i,
  input  logic [N_SLOT-1:0][TID_W-1:0]   slot_tid_i,
  input  logic [N_SLOT-1:0][SEQ_W-1:0]   slot_seq_i,
  input  logic [N_SLOT-1:0][PC_W-1:0]    slot_npc_i,
  input  logic [N_SLOT-1:0][FLAG_W-1:0]  slot_flags_i,
  input  logic                           stores_pend_i,
  output logic [N_SLOT-1:0]              retire_o,
  output logic [CW-1:0]                  used_cnt_o,
  output logic [CW-1:0]                  insn_cnt_o,
  output logic                           nonspec_req_o,
  output logic                           uncached_req_o,
  output logic                           trap_req_o,
  output logic [TID_W-1:0]               req_tid_o,
  output logic [SEQ_W-1:0]               req_seq_o,
  output logic [THREADS-1:0][SEQ_W-1:0]  done_seq_o,
  output logic [THREADS-1:0][PC_W-1:0]   pc_o,
  output logic [THREADS-1:0][PC_W-1:0]   npc_o,
  output logic [CNT_W-1:0]               insn_total_o,
  output logic [CNT_W-1:0]               bw_events_o,
  output logic                           err_o
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // slot examination chain
  logic [N_SLOT:0]          go_c;
  logic [N_SLOT:0][CW-1:0]  cnt_c;
  slot_act_e                act [N_SLOT];
  logic [N_SLOT-1:0]        commit_v;
  logic                     err_evt;

  assign go_c[0]  = 1'b1;
  assign cnt_c[0] = '0;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    hsq_slot_eval #(.COMMIT_W(COMMIT_W), .CW(CW)) u_eval (
      .go_i         (go_c[g]),
      .cnt_i        (cnt_c[g]),
      .vld_i        (slot_vld_i[g]),
      .rdy_i        (slot_rdy_i[g]),
      .flags_i      (slot_flags_i[g]),
      .stores_pend_i(stores_pend_i),
      .go_o         (go_c[g+1]),
      .cnt_o        (cnt_c[g+1]),
      .act_o        (act[g])
    );
  end

  assign used_cnt_o = cnt_c[N_SLOT];

  // merge slot actions; at most one slot ends the walk with a request
  always_comb begin
    retire_o       = '0;
    commit_v       = '0;
    insn_cnt_o     = '0;
    nonspec_req_o  = 1'b0;
    uncached_req_o = 1'b0;
    trap_req_o     = 1'b0;
    err_evt        = 1'b0;
    req_tid_o      = '0;
    req_seq_o      = '0;
    for (int k = 0; k < N_SLOT; k++) begin
      retire_o[k] = (act[k] == ACT_RETIRE_SQ) || (act[k] == ACT_COMMIT);
      commit_v[k] = (act[k] == ACT_COMMIT);
      if (commit_v[k] && !slot_flags_i[k][FL_NOP] && !slot_flags_i[k][FL_IPREF])
        insn_cnt_o = insn_cnt_o + CW'(1);
      if (act[k] == ACT_NONSPEC)  nonspec_req_o  = 1'b1;
      if (act[k] == ACT_UNCACHED) uncached_req_o = 1'b1;
      if (act[k] == ACT_TRAP)     trap_req_o     = 1'b1;
      if (act[k] == ACT_ERROR)    err_evt        = 1'b1;
      if ((act[k] == ACT_NONSPEC) || (act[k] == ACT_UNCACHED) || (act[k] == ACT_TRAP)) begin
        req_tid_o = slot_tid_i[k];
        req_seq_o = slot_seq_i[k];
      end
    end
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    hsq_thread_state #(
      .TID(t), .N_SLOT(N_SLOT), .TID_W(TID_W), .SEQ_W(SEQ_W), .PC_W(PC_W)
    ) u_thr (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .commit_i  (commit_v),
      .tid_i     (slot_tid_i),
      .seq_i     (slot_seq_i),
      .npc_i     (slot_npc_i),
      .done_seq_o(done_seq_o[t]),
      .pc_o      (pc_o[t]),
      .npc_o     (npc_o[t])
    );
  end

  hsq_stats #(.COMMIT_W(COMMIT_W), .CW(CW), .CNT_W(CNT_W)) u_stats (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .used_cnt_i  (used_cnt_o),
    .insn_cnt_i  (insn_cnt_o),
    .err_evt_i   (err_evt),
    .insn_total_o(insn_total_o),
    .bw_events_o (bw_events_o),
    .err_o       (err_o)
  );

  AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_s_n)
    used_cnt_o <= CW'(COMMIT_W)) // R1
    else $error("commit width exceeded");
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({nonspec_req_o, uncached_req_o, trap_req_o, err_evt})) // R4
    else $error("more than one terminating request");
  AST_NONSPEC_SLOT0: assert property (@(posedge clk) disable iff (!rst_s_n)
    nonspec_req_o |-> (used_cnt_o == '0)) // R4
    else $error("non-speculative request behind a commit");
  AST_TRAP_SLOT0: assert property (@(posedge clk) disable iff (!rst_s_n)
    trap_req_o |-> (used_cnt_o == '0) && !stores_pend_i) // R6
    else $error("trap raised behind a commit or with stores pending");
  AST_REQ_NO_RETIRE_ALL: assert property (@(posedge clk) disable iff (!rst_s_n)
    (trap_req_o || uncached_req_o) |-> (retire_o != '1)) // R5
    else $error("request raised while every slot retired");
endmodule

// File: tb/tb_hsq_commit_seq.sv
`timescale 1ns/1ps
module tb_hsq_commit_seq;
  import hsq_pkg::*;

  localparam int N  = 6;
  localparam int W  = 4;
  localparam int T  = 2;
  localparam int SW = 16;
  localparam int PW = 32;
  localparam int CNW = 32;
  localparam int TW = 1;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0]             vld, rdy;
  logic [N-1:0][TW-1:0]     tid;
  logic [N-1:0][SW-1:0]     seq;
  logic [N-1:0][PW-1:0]     npc;
  logic [N-1:0][FLAG_W-1:0] flg;
  logic                     sp;

  logic [N-1:0]        retire;
  logic [CW-1:0]       used_cnt, insn_cnt;
  logic                ns_req, unc_req, trap_req, err;
  logic [TW-1:0]       req_tid;
  logic [SW-1:0]       req_seq;
  logic [T-1:0][SW-1:0] done_seq;
  logic [T-1:0][PW-1:0] pc, npc_q;
  logic [CNW-1:0]      insn_total, bw_events;

  hsq_commit_seq dut (
    .clk(clk), .rst_n(rst_n),
    .slot_vld_i(vld), .slot_rdy_i(rdy), .slot_tid_i(tid), .slot_seq_i(seq),
    .slot_npc_i(npc), .slot_flags_i(flg), .stores_pend_i(sp),
    .retire_o(retire), .used_cnt_o(used_cnt), .insn_cnt_o(insn_cnt),
    .nonspec_req_o(ns_req), .uncached_req_o(unc_req), .trap_req_o(trap_req),
    .req_tid_o(req_tid), .req_seq_o(req_seq),
    .done_seq_o(done_seq), .pc_o(pc), .npc_o(npc_q),
    .insn_total_o(insn_total), .bw_events_o(bw_events), .err_o(err)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int unsigned seq_base = 100;

  // expected state
  logic [T-1:0][SW-1:0] e_done;
  logic [T-1:0][PW-1:0] e_pc, e_npc;
  longint unsigned      e_total, e_bw;
  bit                   e_err;
  // expected per-cycle outputs
  logic [N-1:0] e_ret;
  int           e_used, e_insn;
  bit           e_ns, e_unc, e_trap;
  logic [TW-1:0] e_rtid;
  logic [SW-1:0] e_rseq;

  task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [FLAG_W-1:0] fbit(int b);
    logic [FLAG_W-1:0] f = '0;
    f[b] = 1'b1;
    return f;
  endfunction

  // compute expected outputs from the requirements
  task automatic model();
    int cnt = 0;
    bit go = 1;
    e_ret = '0; e_insn = 0; e_ns = 0; e_unc = 0; e_trap = 0;
    e_rtid = '0; e_rseq = '0;
    for (int k = 0; k < N; k++) begin
      logic [FLAG_W-1:0] f;
      bit grp, drain;
      if (!go) continue;
      if (cnt >= W || !vld[k] || !rdy[k]) begin go = 0; continue; end
      f = flg[k];
      grp   = f[2] | f[3] | f[4] | f[5];
      drain = f[4] | f[5] | f[6];
      if (f[0]) begin
        e_ret[k] = 1'b1;
      end else if (!f[1]) begin
        go = 0;
        if (grp) begin
          if (!(drain && sp) && cnt == 0) begin e_ns = 1; e_rtid = tid[k]; e_rseq = seq[k]; end
        end else if (f[7]) begin
          e_unc = 1; e_rtid = tid[k]; e_rseq = seq[k];
        end else begin
          e_err = 1;
        end
      end else if (f[8]) begin
        go = 0;
        if (!sp && cnt == 0) begin e_trap = 1; e_rtid = tid[k]; e_rseq = seq[k]; end
      end else begin
        e_ret[k] = 1'b1;
        cnt++;
        if (!f[9] && !f[10]) e_insn++;
        e_done[tid[k]] = seq[k];
        e_pc[tid[k]]   = npc[k];
        e_npc[tid[k]]  = npc[k] + 4;
      end
    end
    e_used = cnt;
    e_total += e_insn;
    if (cnt == W) e_bw++;
  endtask

  task automatic check_regs();
    for (int t = 0; t < T; t++) begin
      chk("R7", "done_seq", done_seq[t], e_done[t]);
      chk("R7", "pc", pc[t], e_pc[t]);
      chk("R7", "npc", npc_q[t], e_npc[t]);
    end
    chk("R8", "insn_total", insn_total, e_total);
    chk("R9", "bw_events", bw_events, e_bw);
    chk("R10", "err", err, e_err);
  endtask

  // inputs are set at a falling edge; sample, clock, then check state
  task automatic run_cycle(string tag);
    #1;
    model();
    chk(tag, "retire", retire, e_ret);
    chk(tag, "used_cnt", used_cnt, e_used);
    chk("R8", "insn_cnt", insn_cnt, e_insn);
    chk("R4", "nonspec_req", ns_req, e_ns);
    chk("R5", "uncached_req", unc_req, e_unc);
    chk("R6", "trap_req", trap_req, e_trap);
    if (e_ns || e_unc || e_trap) begin
      chk("R4", "req_tid", req_tid, e_rtid);
      chk("R4", "req_seq", req_seq, e_rseq);
    end
    @(posedge clk);
    @(negedge clk);
    check_regs();
  endtask

  task automatic clear_slots();
    for (int k = 0; k < N; k++) begin
      vld[k] = 1'b1; rdy[k] = 1'b1; tid[k] = TW'(k % T);
      seq[k] = SW'(seq_base + k);
      npc[k] = ($urandom & 32'hFFFF_FFFC);
      flg[k] = fbit(FL_EXEC);
    end
    seq_base += N;
    sp = 1'b0;
  endtask

  function automatic logic [FLAG_W-1:0] rand_flags();
    int r = $urandom % 32;
    logic [FLAG_W-1:0] f = '0;
    if (r < 18) begin
      f[FL_EXEC] = 1; f[FL_NOP] = ($urandom % 6 == 0); f[FL_IPREF] = ($urandom % 8 == 0);
    end else if (r < 22) begin
      f[FL_SQUASH] = 1; f[FL_EXEC] = $urandom % 2;
    end else if (r < 25) begin
      f[FL_EXEC] = 1; f[FL_FAULT] = 1;
    end else if (r < 29) begin
      f[2 + ($urandom % 4)] = 1; f[FL_QUIESCE] = $urandom % 2;
    end else if (r < 31) begin
      f[FL_LOAD] = 1;
    end else begin
      f[FL_QUIESCE] = $urandom % 2;
    end
    return f;
  endfunction

  initial begin
    #(8 * 190000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    e_done = '0; e_pc = '0; e_npc = '0; e_total = 0; e_bw = 0; e_err = 0;
    clear_slots();
    vld = '0;
    repeat (3) @(negedge clk);
    // R11: state while reset held
    check_regs();
    chk("R11", "err_in_reset", err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "insn_total_after_reset", insn_total, 0);
    chk("R11", "done_seq_after_reset", done_seq, 0);

    // R1: six executed heads, width stops at four
    clear_slots();
    run_cycle("R1");
    // R2: squashed heads do not use width
    clear_slots();
    flg[0] = fbit(FL_SQUASH); flg[1] = fbit(FL_SQUASH) | fbit(FL_EXEC);
    run_cycle("R2");
    // R1: invalid selection stops the walk
    clear_slots();
    vld[1] = 1'b0;
    run_cycle("R1");
    clear_slots();
    rdy[2] = 1'b0;
    run_cycle("R1");
    // R3: barrier waits while stores drain
    clear_slots();
    flg[0] = fbit(FL_MEMBAR); sp = 1'b1;
    run_cycle("R3");
    clear_slots();
    flg[0] = fbit(FL_NONSPEC) | fbit(FL_QUIESCE); sp = 1'b1;
    run_cycle("R3");
    // R4: non-speculative in slot one behind a commit, then in slot zero
    clear_slots();
    flg[1] = fbit(FL_NONSPEC);
    run_cycle("R4");
    clear_slots();
    flg[0] = fbit(FL_STCOND); sp = 1'b1;
    run_cycle("R4");
    // R5: uncached load after commits
    clear_slots();
    flg[2] = fbit(FL_LOAD); sp = 1'b1;
    run_cycle("R5");
    // R6: fault waits with stores pending, then traps
    clear_slots();
    flg[0] = fbit(FL_EXEC) | fbit(FL_FAULT); sp = 1'b1;
    run_cycle("R6");
    clear_slots();
    flg[0] = fbit(FL_EXEC) | fbit(FL_FAULT); tid[0] = 1'b1;
    run_cycle("R6");
    clear_slots();
    flg[0] = fbit(FL_SQUASH); flg[1] = fbit(FL_EXEC) | fbit(FL_FAULT);
    run_cycle("R6");
    // R7: same thread twice, highest slot wins
    clear_slots();
    for (int k = 0; k < N; k++) tid[k] = '0;
    vld[3] = 1'b0;
    run_cycle("R7");
    // R8: nops and prefetches retire but are not counted
    clear_slots();
    flg[0] = fbit(FL_EXEC) | fbit(FL_NOP); flg[2] = fbit(FL_EXEC) | fbit(FL_IPREF);
    run_cycle("R8");
    // R10: unhandled unexecuted head
    clear_slots();
    flg[1] = fbit(FL_QUIESCE);
    run_cycle("R10");
    clear_slots();
    run_cycle("R10");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      clear_slots();
      for (int k = 0; k < N; k++) begin
        vld[k] = ($urandom % 10 != 0);
        rdy[k] = ($urandom % 8 != 0);
        tid[k] = TW'($urandom % T);
        flg[k] = rand_flags();
      end
      sp = ($urandom % 3 == 0);
      run_cycle("R1");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule